// File: doc/BRIEF.md
# Processor Reset Recognizer and Initializer

This block is the reset front end of a small processor core. It takes an external reset level that has already been brought into the core clock domain. It accepts that level as a real reset only after the level has been sampled high on a minimum number of consecutive rising clock edges. Any shorter pulse leaves the core untouched.

Once a reset is accepted, the block raises a halt output that freezes the rest of the core. It keeps that output high for as long as the reset input stays high. While halted, it loads the architectural state with its power-on values:

- The flags, instruction pointer, data segment, stack segment and extra segment are cleared.
- The code segment is set to all ones.
- The prefetch queue is flagged empty.

When the reset input falls, the block drops the halt output and emits a single-cycle start pulse to the fetch engine. In that same cycle it presents the first physical fetch address. That address is the code segment shifted left by four bit positions, plus the instruction pointer.

The chip-level asynchronous reset `rst_ni` only clears the block's own state. It is not the architectural reset described above.

Top module: `cpu_reset_init`

## Requirements
- R1: A reset is accepted only on the clock edge that samples `ext_reset_i` high for the 4th consecutive time (MIN_HIGH = 4). Two conditions follow from this. `halt_o` is high after that edge. A run of 3 highs followed by a low leaves `halt_o`, `start_fetch_o` and `cs_o` unchanged.
- R2: The count of consecutive highs restarts whenever `ext_reset_i` is sampled low. For example, 2 highs, then 1 low, then 3 highs does not raise `halt_o`.
- R3: Once `halt_o` is high, it stays high on every edge at which `ext_reset_i` is sampled high, however long the input is held.
- R4: While `halt_o` is high, `flags_o`, `ip_o`, `ds_o`, `ss_o` and `es_o` all read 16'h0000.
- R5: While `halt_o` is high, `cs_o` reads 16'hFFFF.
- R6: While `halt_o` is high, `queue_empty_o` reads 1.
- R7: On the first edge that samples `ext_reset_i` low while halted, `halt_o` falls and `start_fetch_o` goes high. On the next edge, `start_fetch_o` goes low again, so the pulse lasts exactly one cycle. `start_fetch_o` is never high unless `halt_o` was high in the cycle before.
- R8: While `start_fetch_o` is high, `fetch_addr_o` reads 20'hFFFF0, which is (`cs_o` << 4) + `ip_o`, truncated to 20 bits.
- R9: After `rst_ni` is released, and before any accepted reset, the outputs read as follows. `halt_o`, `start_fetch_o` and `queue_empty_o` are 0. All six register outputs are 16'h0000. `fetch_addr_o` is 20'h00000.
- R10: If `ext_reset_i` rises again in the same cycle as the start pulse, the pulse still lasts exactly one cycle. The new reset again needs 4 full consecutive highs before it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low chip reset of the block's own state |
| ext_reset_i | input | 1 | Synchronized external reset level, active high |
| halt_o | output | 1 | Core frozen; high from acceptance until release |
| start_fetch_o | output | 1 | One-cycle pulse telling the fetch engine to start |
| fetch_addr_o | output | 20 | Physical address of the first fetch |
| flags_o | output | 16 | Flags register value |
| ip_o | output | 16 | Instruction pointer value |
| cs_o | output | 16 | Code segment value |
| ds_o | output | 16 | Data segment value |
| ss_o | output | 16 | Stack segment value |
| es_o | output | 16 | Extra segment value |
| queue_empty_o | output | 1 | Prefetch queue marked empty |

## Verification
Two functions can fall in the same cycle: emitting the start pulse on release, and counting the first high sample of a new reset attempt. The bench provokes this by releasing an accepted reset and raising `ext_reset_i` again at the very sample where `start_fetch_o` appears.

The bench judges the result on three points:
- The pulse must still vanish after one cycle.
- `halt_o` must stay low through the next three high samples.
- `halt_o` must return only on the fourth high sample.

A design that bridges straight from the pulse back into halt, or that carries the count across the release, fails this sequence.

// File: rtl/cpu_rst_pkg.sv
package cpu_rst_pkg;
  parameter int unsigned WORD_W    = 16;
  parameter int unsigned ADDR_W    = 20;
  parameter int unsigned SEG_SHIFT = 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] paddr_t;

  typedef struct packed {
    word_t flags;
    word_t ip;
    word_t cs;
    word_t ds;
    word_t ss;
    word_t es;
    logic  q_empty;
  } arch_state_t;

  localparam word_t CS_AT_RESET   = '1;
  localparam word_t ZERO_AT_RESET = '0;

  function automatic arch_state_t reset_state();
    arch_state_t s;
    s.flags   = ZERO_AT_RESET;
    s.ip      = ZERO_AT_RESET;
    s.cs      = CS_AT_RESET;
    s.ds      = ZERO_AT_RESET;
    s.ss      = ZERO_AT_RESET;
    s.es      = ZERO_AT_RESET;
    s.q_empty = 1'b1;
    return s;
  endfunction

  function automatic paddr_t phys_addr(word_t seg, word_t off);
    paddr_t s;
    paddr_t o;
    s = paddr_t'(seg) << SEG_SHIFT;
    o = paddr_t'(off);
    return s + o;
  endfunction
endpackage

// File: rtl/rst_filter.sv
module rst_filter #(
  parameter int unsigned MIN_HIGH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic accept_o
);
  generate
    if (MIN_HIGH <= 1) begin : g_direct
      assign accept_o = level_i;
    end else begin : g_count
      localparam int unsigned CW = $clog2(MIN_HIGH + 1);
      localparam logic [CW-1:0] SAT  = CW'(MIN_HIGH);
      localparam logic [CW-1:0] LAST = CW'(MIN_HIGH - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          cnt_q <= '0;
        else if (!level_i)    cnt_q <= '0;
        else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
      end

      // current sample completes the run
      assign accept_o = level_i && (cnt_q >= LAST);
    end
  endgenerate
endmodule

// File: rtl/rst_ctrl.sv
module rst_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic accept_i,
  output logic held_o,
  output logic held_next_o,
  output logic start_o
);
  logic held_q, start_q;
  logic start_d;

  assign held_next_o = held_q ? level_i : accept_i;
  assign start_d     = held_q && !level_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      held_q  <= held_next_o;
      start_q <= start_d;
    end
  end

  assign held_o  = held_q;
  assign start_o = start_q;
endmodule

// File: rtl/rst_state_reg.sv
module rst_state_reg
  import cpu_rst_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  output arch_state_t state_o
);
  arch_state_t state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= '0;
    else if (load_i) state_q <= reset_state();
  end

  assign state_o = state_q;
endmodule

// File: rtl/cpu_reset_init.sv
module cpu_reset_init
  import cpu_rst_pkg::*;
#(
  parameter int unsigned MIN_HIGH = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ext_reset_i,
  output logic                halt_o,
  output logic                start_fetch_o,
  output logic [ADDR_W-1:0]   fetch_addr_o,
  output logic [WORD_W-1:0]   flags_o,
  output logic [WORD_W-1:0]   ip_o,
  output logic [WORD_W-1:0]   cs_o,
  output logic [WORD_W-1:0]   ds_o,
  output logic [WORD_W-1:0]   ss_o,
  output logic [WORD_W-1:0]   es_o,
  output logic                queue_empty_o
);
  logic        accept;
  logic        held_next;
  arch_state_t state;

  rst_filter #(.MIN_HIGH(MIN_HIGH)) u_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (ext_reset_i),
    .accept_o (accept)
  );

  rst_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .level_i     (ext_reset_i),
    .accept_i    (accept),
    .held_o      (halt_o),
    .held_next_o (held_next),
    .start_o     (start_fetch_o)
  );

  // state is reloaded on every edge that leaves the core halted
  rst_state_reg u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (held_next),
    .state_o (state)
  );

  assign flags_o       = state.flags;
  assign ip_o          = state.ip;
  assign cs_o          = state.cs;
  assign ds_o          = state.ds;
  assign ss_o          = state.ss;
  assign es_o          = state.es;
  assign queue_empty_o = state.q_empty;
  assign fetch_addr_o  = phys_addr(state.cs, state.ip);
endmodule

// File: rtl/cpu_reset_init_chk.sv
module cpu_reset_init_chk
  import cpu_rst_pkg::*;
#(
  parameter int unsigned MIN_HIGH = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ext_reset_i,
  input logic                halt_o,
  input logic                start_fetch_o,
  input logic [ADDR_W-1:0]   fetch_addr_o,
  input logic [WORD_W-1:0]   flags_o,
  input logic [WORD_W-1:0]   ip_o,
  input logic [WORD_W-1:0]   cs_o,
  input logic [WORD_W-1:0]   ds_o,
  input logic [WORD_W-1:0]   ss_o,
  input logic [WORD_W-1:0]   es_o,
  input logic                queue_empty_o
);
  localparam int unsigned HW = $clog2(MIN_HIGH + 2);
  localparam logic [ADDR_W-1:0] FIRST_FETCH = ADDR_W'(20'hFFFF0);
  logic [HW-1:0] run_q;

  // independent run length of the input
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      run_q <= '0;
    else if (!ext_reset_i)            run_q <= '0;
    else if (run_q < HW'(MIN_HIGH))   run_q <= run_q + 1'b1;
  end

  p_accept_after_run_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> run_q >= HW'(MIN_HIGH));

  p_hold_while_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o && ext_reset_i |=> halt_o);

  p_zero_regs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (flags_o == '0) && (ip_o == '0) && (ds_o == '0) && (ss_o == '0) && (es_o == '0));

  p_cs_ones_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> cs_o == WORD_W'(16'hFFFF));

  p_queue_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> queue_empty_o);

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o && !ext_reset_i |=> start_fetch_o && !halt_o);

  p_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_fetch_o |=> !start_fetch_o);

  p_start_needs_halt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_fetch_o) |-> $past(halt_o));

  p_first_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_fetch_o |-> fetch_addr_o == FIRST_FETCH);

  p_no_bridge_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_fetch_o |=> !halt_o);
endmodule

bind cpu_reset_init cpu_reset_init_chk #(.MIN_HIGH(MIN_HIGH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ext_reset_i   (ext_reset_i),
  .halt_o        (halt_o),
  .start_fetch_o (start_fetch_o),
  .fetch_addr_o  (fetch_addr_o),
  .flags_o       (flags_o),
  .ip_o          (ip_o),
  .cs_o          (cs_o),
  .ds_o          (ds_o),
  .ss_o          (ss_o),
  .es_o          (es_o),
  .queue_empty_o (queue_empty_o)
);

// File: tb/cpu_reset_init_test.sv
`timescale 1ns/1ps
module cpu_reset_init_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_reset_i = 1'b0;
  logic        halt_o, start_fetch_o, queue_empty_o;
  logic [19:0] fetch_addr_o;
  logic [15:0] flags_o, ip_o, cs_o, ds_o, ss_o, es_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  cpu_reset_init #(.MIN_HIGH(4)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_reset_i(ext_reset_i),
    .halt_o(halt_o), .start_fetch_o(start_fetch_o), .fetch_addr_o(fetch_addr_o),
    .flags_o(flags_o), .ip_o(ip_o), .cs_o(cs_o), .ds_o(ds_o), .ss_o(ss_o),
    .es_o(es_o), .queue_empty_o(queue_empty_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    ext_reset_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk_arch(input string req);
    chk(flags_o == 16'h0 && ip_o == 16'h0 && ds_o == 16'h0 && ss_o == 16'h0 && es_o == 16'h0,
        {req, " R4 zeroed regs"}, {flags_o | ip_o | ds_o | ss_o | es_o}, 32'h0);
    chk(cs_o == 16'hFFFF, {req, " R5 cs"}, cs_o, 32'hFFFF);
    chk(queue_empty_o == 1'b1, {req, " R6 queue empty"}, queue_empty_o, 1);
  endtask

  task automatic t_reset_state();
    chk(halt_o == 1'b0, "R9 halt", halt_o, 0);
    chk(start_fetch_o == 1'b0, "R9 start", start_fetch_o, 0);
    chk(queue_empty_o == 1'b0, "R9 queue", queue_empty_o, 0);
    chk(cs_o == 16'h0 && ip_o == 16'h0 && flags_o == 16'h0, "R9 regs", {cs_o, ip_o}, 0);
    chk(fetch_addr_o == 20'h0, "R9 addr", fetch_addr_o, 0);
  endtask

  task automatic t_short_pulse();
    idle(2);
    ext_reset_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(halt_o == 1'b0, "R1 short pulse halt", halt_o, 0);
    end
    ext_reset_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(start_fetch_o == 1'b0, "R1 short pulse start", start_fetch_o, 0);
    end
    chk(cs_o == 16'h0, "R1 short pulse cs", cs_o, 0);
  endtask

  task automatic t_broken_run();
    idle(2);
    ext_reset_i = 1'b1;
    repeat (2) @(negedge clk_i);
    ext_reset_i = 1'b0;
    @(negedge clk_i);
    ext_reset_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(halt_o == 1'b0, "R2 count restarted", halt_o, 0);
    @(negedge clk_i);
    chk(halt_o == 1'b1, "R1 fourth high accepted", halt_o, 1);
    chk_arch("accept");
  endtask

  task automatic t_long_hold();
    bit ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (!halt_o || start_fetch_o) ok = 1'b0;
    end
    chk(ok, "R3 halt held for 40 cycles", ok, 1);
    chk_arch("hold");
  endtask

  task automatic t_release();
    ext_reset_i = 1'b0;
    @(negedge clk_i);
    chk(halt_o == 1'b0, "R7 halt falls", halt_o, 0);
    chk(start_fetch_o == 1'b1, "R7 start pulse", start_fetch_o, 1);
    chk(fetch_addr_o == 20'hFFFF0, "R8 first fetch addr", fetch_addr_o, 20'hFFFF0);
    @(negedge clk_i);
    chk(start_fetch_o == 1'b0, "R7 pulse one cycle", start_fetch_o, 0);
    repeat (3) @(negedge clk_i);
    chk(start_fetch_o == 1'b0 && halt_o == 1'b0, "R7 quiet after", {halt_o, start_fetch_o}, 0);
  endtask

  task automatic t_reassert_on_pulse();
    idle(2);
    ext_reset_i = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(halt_o == 1'b1, "R10 initial accept", halt_o, 1);
    ext_reset_i = 1'b0;
    @(negedge clk_i);
    chk(start_fetch_o == 1'b1, "R10 pulse", start_fetch_o, 1);
    ext_reset_i = 1'b1;
    @(negedge clk_i);
    chk(start_fetch_o == 1'b0, "R10 pulse one cycle", start_fetch_o, 0);
    chk(halt_o == 1'b0, "R10 no bridge", halt_o, 0);
    repeat (2) @(negedge clk_i);
    chk(halt_o == 1'b0, "R10 third high not yet", halt_o, 0);
    @(negedge clk_i);
    chk(halt_o == 1'b1, "R10 fourth high accepted", halt_o, 1);
    ext_reset_i = 1'b0;
    @(negedge clk_i);
    chk(start_fetch_o == 1'b1 && fetch_addr_o == 20'hFFFF0, "R10 R8 second start",
        fetch_addr_o, 20'hFFFF0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_state();
    t_short_pulse();
    t_broken_run();
    t_long_hold();
    t_release();
    t_reassert_on_pulse();
    idle(3);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule